// File: doc/BRIEF.md
# Busy-Indicated Serial Converter Reader

This block is the host-side sequencer for one successive-approximation converter wired in three-wire select mode, where the converter's data line also reports that a conversion has finished. A start request in idle raises the convert strobe for a set number of system-clock cycles and then drops it. The data-input pin of the converter is held high for the whole time. With the strobe low, the block watches the pulled-up serial data line, after a two-flop synchroniser. A falling edge on that line means the result is ready.

The block then produces serial clock pulses with a programmable half period. It shifts in one bit after each of the first eighteen falling edges, most significant bit first. It then gives a nineteenth falling edge so that the converter releases the line. The assembled word is presented with a one-cycle valid strobe. If the line never falls within a window measured from the strobe's fall, an error flag is raised and the block returns to idle. Start requests that arrive while a cycle is running are dropped.

Top module: `adc_busy_reader`

## Requirements
- R1: After reset, cnv, sck, data_valid and timeout_err are 0 and data_out is all zeros.
- R2: sdi is driven 1 on every cycle, including during conversion and readout.
- R3: A start sampled high in idle raises cnv for exactly CNV_HI clock cycles, after which cnv goes low.
- R4: cnv stays low from its fall until the cycle ends, and is never high while sck is high.
- R5: No sck pulse occurs before sdo_in has fallen from its pulled-high level after the conversion request.
- R6: During readout every sck high phase lasts HALF cycles, and every sck low phase between two falling edges lasts HALF cycles. Exactly 19 sck falling edges are issued per conversion, and sck rests at 0 outside readout.
- R7: The level of sdo_in after falling edge k (k = 1..18) becomes bit 18-k of data_out, so bit 17 is the first bit received and bit 0 the last.
- R8: data_valid pulses for exactly one cycle, in the same cycle as the 19th sck falling edge, carrying the assembled word. data_out keeps that value until the next word is delivered.
- R9: A start asserted while a cycle is in progress has no effect: each accepted request produces exactly one cnv rising edge.
- R10: If sdo_in has not fallen when CONV_MAX+TIMEOUT cycles have passed since cnv fell, timeout_err rises in that cycle, no sck pulse is issued and the block returns to idle. timeout_err stays set until the next accepted start clears it.
- R11: After a completed read or a timeout, a new start is accepted and runs a full cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, sampled in idle |
| sdo_in | input | 1 | Serial data from the converter, pulled high when released |
| cnv | output | 1 | Convert strobe to the converter |
| sdi | output | 1 | Converter data-input pin, held high |
| sck | output | 1 | Serial clock to the converter |
| data_out | output | 18 | Last assembled conversion result |
| data_valid | output | 1 | One-cycle strobe marking a new result |
| timeout_err | output | 1 | Set when completion is not seen in time |

## Verification
If the state register or the counter is corrupted, the fault shows at the ports within one conversion. A wrong counter appears as a convert strobe or serial clock phase of the wrong length, which is measured in cycles on the first pulse. A bad shift register or edge count appears as a wrong word or a valid strobe that does not line up with the 19th falling edge. A broken busy detector shows up either as clock pulses while the data line is still high, or as a timeout flag that rises at the wrong distance from the strobe's fall.

// File: rtl/adc_busy_reader.sv
module adc_busy_reader #(
  parameter int CNV_HI   = 3,
  parameter int CONV_MAX = 40,
  parameter int TIMEOUT  = 30,
  parameter int HALF     = 4,
  parameter int BITS     = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            sdo_in,
  output logic            cnv,
  output logic            sdi,
  output logic            sck,
  output logic [BITS-1:0] data_out,
  output logic            data_valid,
  output logic            timeout_err
);
  localparam int LIMIT = CONV_MAX + TIMEOUT;
  localparam int CW    = $clog2(LIMIT + CNV_HI + HALF + 1) + 1;
  localparam int EW    = $clog2(BITS + 2) + 1;

  typedef enum logic [1:0] {S_IDLE, S_HI, S_WAIT, S_RD} st_t;

  st_t             state;
  logic [CW-1:0]   cnt;
  logic [EW-1:0]   edges;
  logic [BITS-1:0] shreg;
  logic            sdo_m, sdo_s, sdo_p;
  logic            sdo_fell;

  assign sdi      = 1'b1;
  assign sdo_fell = sdo_p & ~sdo_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      edges       <= '0;
      shreg       <= '0;
      cnv         <= 1'b0;
      sck         <= 1'b0;
      data_out    <= '0;
      data_valid  <= 1'b0;
      timeout_err <= 1'b0;
      sdo_m       <= 1'b1;
      sdo_s       <= 1'b1;
      sdo_p       <= 1'b1;
    end else begin
      data_valid <= 1'b0;
      sdo_m      <= sdo_in;
      sdo_s      <= sdo_m;
      sdo_p      <= sdo_s;
      case (state)
        S_IDLE: begin
          if (start) begin
            state       <= S_HI;
            cnv         <= 1'b1;
            cnt         <= '0;
            timeout_err <= 1'b0;
          end
        end
        S_HI: begin
          if (cnt == CW'(CNV_HI - 1)) begin
            cnv   <= 1'b0;
            cnt   <= '0;
            state <= S_WAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (sdo_fell) begin
            state <= S_RD;
            cnt   <= '0;
            edges <= '0;
            sck   <= 1'b0;
          end else if (cnt == CW'(LIMIT - 1)) begin
            timeout_err <= 1'b1;
            state       <= S_IDLE;
            cnt         <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RD: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            sck <= ~sck;
            if (!sck && edges != '0)
              shreg <= {shreg[BITS-2:0], sdo_s};
            if (sck) begin
              edges <= edges + 1'b1;
              if (edges == EW'(BITS)) begin
                state      <= S_IDLE;
                data_out   <= shreg;
                data_valid <= 1'b1;
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_CNV_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv) |-> $past(state) == S_IDLE); // R9
  AST_SCK_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    state != S_RD |-> !sck); // R6
  AST_CNV_LOW_DURING_SCK: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cnv); // R4
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid); // R8
  AST_NO_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> !timeout_err); // R10
  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    edges <= EW'(BITS + 1)); // R6
endmodule

// File: tb/adc_busy_reader_test.sv
module adc_busy_reader_test;
  localparam int PERIOD   = 10;
  localparam int CNV_HI   = 3;
  localparam int CONV_MAX = 40;
  localparam int TIMEOUT  = 30;
  localparam int HALF     = 4;
  localparam int CONV_T   = 25;
  localparam int LIMIT    = CONV_MAX + TIMEOUT;

  logic clk = 0, rst_n = 0, start = 0, sdo_in = 1;
  logic cnv, sdi, sck, data_valid, timeout_err;
  logic [17:0] data_out;

  adc_busy_reader #(.CNV_HI(CNV_HI), .CONV_MAX(CONV_MAX), .TIMEOUT(TIMEOUT),
                    .HALF(HALF), .BITS(18)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .sdo_in(sdo_in), .cnv(cnv),
    .sdi(sdi), .sck(sck), .data_out(data_out), .data_valid(data_valid),
    .timeout_err(timeout_err));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [17:0] word = 0;
  bit respond = 1;
  bit converting = 0, data_out_phase = 0;
  int conv_left = 0, falls = 0, hi_run = 0, sck_run = 0, since_fall = 0, rises = 0;
  logic cnv_q = 0, sck_q = 0, err_q = 0, valid_q = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(sdi === 1'b1, "R2", sdi, 1);
      if (cnv && !cnv_q) begin
        rises++;
        hi_run = 0;
        converting = 1;
        data_out_phase = 0;
        conv_left = CONV_T;
        sdo_in = 1;
        falls = 0;
      end
      if (cnv) hi_run++;
      if (!cnv && cnv_q) begin
        chk(hi_run == CNV_HI, "R3", hi_run, CNV_HI);
        since_fall = 0;
      end else if (!cnv) since_fall++;
      if (converting) begin
        if (conv_left == 0) begin
          converting = 0;
          if (respond) begin sdo_in = 0; data_out_phase = 1; end
        end else conv_left--;
      end
      if (sck && !data_out_phase) chk(0, "R5", sck, 0);
      if (sck) chk(!cnv, "R4", cnv, 0);
      if (sck != sck_q) begin
        if (sck_q) chk(sck_run == HALF, "R6", sck_run, HALF);
        else if (falls >= 1) chk(sck_run == HALF, "R6", sck_run, HALF);
        sck_run = 1;
      end else sck_run++;
      if (!sck && sck_q) begin
        falls++;
        if (falls <= 18) sdo_in = word[18 - falls];
        else begin sdo_in = 1; data_out_phase = 0; end
      end
      if (valid_q) chk(!data_valid, "R8", data_valid, 0);
      if (data_valid) begin
        chk(falls == 19, "R8", falls, 19);
        chk(data_out == word, "R7", data_out, word);
      end
      if (timeout_err && !err_q) begin
        chk(since_fall == LIMIT, "R10", since_fall, LIMIT);
        chk(falls == 0, "R10", falls, 0);
      end
    end
    cnv_q = cnv; sck_q = sck; err_q = timeout_err; valid_q = data_valid;
  end

  task automatic run_op(logic [17:0] w, bit resp, bit extra);
    bit done = 0;
    int r0;
    word = w; respond = resp;
    r0 = rises;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 2000 && !done; i++) begin
      @(negedge clk);
      if (extra && (i == 5 || i == 60)) start = 1; else start = 0;
      if (data_valid || (timeout_err && !resp)) done = 1;
    end
    start = 0;
    chk(done, resp ? "R11" : "R10", done, 1);
    chk(rises - r0 == 1, "R9", rises - r0, 1);
    repeat (3) @(negedge clk);
    chk(!cnv && !sck, "R6", {cnv, sck}, 0);
    if (resp) begin
      chk(data_out == w, "R8", data_out, w);
      chk(!timeout_err, "R10", timeout_err, 0);
    end else begin
      chk(timeout_err, "R10", timeout_err, 1);
      chk(!cnv, "R10", cnv, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cnv == 0 && sck == 0 && data_valid == 0 && timeout_err == 0, "R1",
        {cnv, sck, data_valid, timeout_err}, 0);
    chk(data_out == 0, "R1", data_out, 0);
    rst_n = 1;
    run_op(18'h2AAAA, 1, 0);
    run_op(18'h15555, 1, 1);
    run_op(18'h3FFFF, 1, 0);
    run_op(18'h00000, 1, 1);
    run_op(18'h20001, 1, 0);
    run_op(18'h1234A, 0, 0);
    run_op(18'h0F0F3, 1, 1);
    run_op(18'h1234A, 0, 1);
    run_op(18'h3C001, 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule